// File: doc/BRIEF.md
# Virtual Timer Compare Access Router

This block settles what happens to a 64-bit register-pair read or write aimed at the virtual timer compare register. Each request carries the current privilege level (0 to 3), the security state, a host-mode flag, the presence of optional features, the 32/64-bit mode of levels 1 and 2, and the access-enable and trap-control bits of the surrounding levels. One cycle after the request strobe the block answers with one of these outcomes:

- an undefined-instruction result;
- a trap to level 1 or level 2 carrying a syndrome code;
- a hypervisor-mode trap;
- an access to one of three physical compare registers.

Those three backing registers are held inside the block. A permitted read returns the selected value. A permitted write updates only the selected register. Reads and writes go through the same decision chain and differ only in which way the data moves. Taking the exceptions themselves is left to the core.

Top module: `vtimer_cmp_router`

## Requirements
- R1: When 32-bit execution support is absent (`aa32_i`=0), every request yields outcome UNDEF (`rsp_kind_o`=1), with level 0, code 0 and selector 0, before any other check.
- R2: At level 0, if level 1 is 64-bit, host mode is off and `l0_timer_en64_i`=0, the outcome is TRAP (`rsp_kind_o`=2) with code 0x04. The target level is 2 if level 2 is enabled, is 64-bit and has `trap_gen_i`=1. Otherwise the target level is 1.
- R3: At level 0, if level 1 is 32-bit and `l0_timer_en32_i`=0, three cases apply in order. If level 2 is enabled, 64-bit and `trap_gen_i`=1, the outcome is TRAP to level 2 with code 0x04. Otherwise, if level 2 is enabled, 32-bit and `trap_gen_i`=1, the outcome is HYP_TRAP (`rsp_kind_o`=3) at level 2 with code 0x00. Otherwise the outcome is UNDEF.
- R4: At level 0 in host mode, if level 2 is 64-bit and `host_l0_timer_en_i`=0, the outcome is TRAP to level 2 with code 0x04.
- R5: A level-2 timer trap applies when all of the following hold: level 2 is enabled, level 2 is 64-bit, `cnt_virt_ext_i`=1 and `l1_timer_trap_i`=1. It traps level-0 requests made outside host mode, and all level-1 requests, to level 2 with code 0x04.
- R6: A level-0 request that passes every check is an ACCESS (`rsp_kind_o`=0). It selects register 2 (secure hypervisor-virtual) when host mode is on, the state is secure and `sec_l2_i`=1. It selects register 1 (non-secure hypervisor-virtual) when host mode is on and the state is non-secure. Otherwise it selects register 0 (plain virtual).
- R7: A level-1 request that is not trapped by R5 is an ACCESS to register 0. Requests at levels 2 and 3 are always an ACCESS to register 0.
- R8: `rsp_valid_o` is high for exactly the cycle after each cycle in which `req_i` is high, and low otherwise.
- R9: A read ACCESS returns the selected register's value on `rdata_o` together with `rsp_valid_o`. For writes and for any non-ACCESS outcome, `rdata_o` is 0.
- R10: A write ACCESS updates only the selected register. A write with any other outcome changes no register.
- R11: Reset clears `rsp_valid_o` and all three registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 64 | Write data |
| level_i | input | 2 | Current privilege level |
| secure_i | input | 1 | Secure state |
| host_i | input | 1 | Level 0 runs under a host-mode level 2 |
| aa32_i | input | 1 | 32-bit execution supported |
| l1_64_i | input | 1 | Level 1 runs 64-bit (else 32-bit) |
| l2_en_i | input | 1 | Level 2 enabled |
| l2_64_i | input | 1 | Level 2 runs 64-bit (else 32-bit) |
| sec_l2_i | input | 1 | Secure level 2 present |
| cnt_virt_ext_i | input | 1 | Extended counter virtualisation present |
| l0_timer_en64_i | input | 1 | Level-0 timer enable held by a 64-bit level 1 |
| l0_timer_en32_i | input | 1 | Level-0 timer enable held by a 32-bit level 1 |
| host_l0_timer_en_i | input | 1 | Level-0 timer enable held by level 2 in host mode |
| trap_gen_i | input | 1 | Level 2 routes general level-0 exceptions to itself |
| l1_timer_trap_i | input | 1 | Level 2 traps lower-level virtual timer accesses |
| rsp_valid_o | output | 1 | Response valid |
| rsp_kind_o | output | 3 | 0 ACCESS, 1 UNDEF, 2 TRAP, 3 HYP_TRAP |
| rsp_level_o | output | 2 | Target level of a trap |
| rsp_code_o | output | 8 | Syndrome code |
| rsp_sel_o | output | 2 | Register selected by an ACCESS |
| rdata_o | output | 64 | Read data |

## Verification
A wrong branch in the priority chain shows up as a wrong kind, level or code on the response that follows the request. A wrong selector on a write stays hidden at first. It appears only when one of the three registers is later read back, so the bench reads the registers often between random writes. A register touched by a trapped write is likewise visible only on the next permitted read of that register.

// File: rtl/vtcr_pkg.sv
package vtcr_pkg;
  localparam int unsigned NUM_TARGETS = 3;
  localparam int unsigned SEL_W       = $clog2(NUM_TARGETS);

  typedef enum logic [2:0] {
    OUT_ACCESS   = 3'd0,
    OUT_UNDEF    = 3'd1,
    OUT_TRAP     = 3'd2,
    OUT_HYP_TRAP = 3'd3
  } outcome_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_VIRT  = 2'd0,
    SEL_HV_NS = 2'd1,
    SEL_HV_S  = 2'd2
  } sel_e;

  typedef struct packed {
    logic [1:0] level;
    logic       secure;
    logic       host;
    logic       aa32;
    logic       l1_64;
    logic       l2_en;
    logic       l2_64;
    logic       sec_l2;
    logic       cnt_virt_ext;
    logic       l0_en64;
    logic       l0_en32;
    logic       host_l0_en;
    logic       trap_gen;
    logic       l1_trap;
  } ctx_t;
endpackage

// File: rtl/vtcr_decide.sv
module vtcr_decide
  import vtcr_pkg::*;
#(
  parameter int unsigned       CODE_W    = 8,
  parameter logic [CODE_W-1:0] TRAP_CODE = 8'h04,
  parameter logic [CODE_W-1:0] HYP_CODE  = 8'h00
) (
  input  ctx_t              ctx_i,
  output outcome_e          kind_o,
  output logic [1:0]        lvl_o,
  output logic [CODE_W-1:0] code_o,
  output sel_e              sel_o
);
  logic l2_64_on, l2_32_on, timer_trap;

  assign l2_64_on   = ctx_i.l2_en & ctx_i.l2_64;
  assign l2_32_on   = ctx_i.l2_en & ~ctx_i.l2_64;
  assign timer_trap = l2_64_on & ctx_i.cnt_virt_ext & ctx_i.l1_trap;

  // strict first-match priority chain
  always_comb begin
    kind_o = OUT_ACCESS;
    lvl_o  = 2'd0;
    code_o = '0;
    sel_o  = SEL_VIRT;
    if (!ctx_i.aa32) begin
      kind_o = OUT_UNDEF;
    end else if (ctx_i.level == 2'd0) begin
      if (ctx_i.l1_64 && !ctx_i.host && !ctx_i.l0_en64) begin
        kind_o = OUT_TRAP;
        code_o = TRAP_CODE;
        lvl_o  = (l2_64_on && ctx_i.trap_gen) ? 2'd2 : 2'd1;
      end else if (!ctx_i.l1_64 && !ctx_i.l0_en32) begin
        if (l2_64_on && ctx_i.trap_gen) begin
          kind_o = OUT_TRAP;
          code_o = TRAP_CODE;
          lvl_o  = 2'd2;
        end else if (l2_32_on && ctx_i.trap_gen) begin
          kind_o = OUT_HYP_TRAP;
          code_o = HYP_CODE;
          lvl_o  = 2'd2;
        end else begin
          kind_o = OUT_UNDEF;
        end
      end else if (ctx_i.host && ctx_i.l2_64 && !ctx_i.host_l0_en) begin
        kind_o = OUT_TRAP;
        code_o = TRAP_CODE;
        lvl_o  = 2'd2;
      end else if (!ctx_i.host && timer_trap) begin
        kind_o = OUT_TRAP;
        code_o = TRAP_CODE;
        lvl_o  = 2'd2;
      end else if (ctx_i.host && ctx_i.secure && ctx_i.sec_l2) begin
        sel_o = SEL_HV_S;
      end else if (ctx_i.host && !ctx_i.secure) begin
        sel_o = SEL_HV_NS;
      end
    end else if (ctx_i.level == 2'd1) begin
      if (timer_trap) begin
        kind_o = OUT_TRAP;
        code_o = TRAP_CODE;
        lvl_o  = 2'd2;
      end
    end
  end
endmodule

// File: rtl/vtcr_bank.sv
module vtcr_bank
  import vtcr_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [NUM_TARGETS];
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  for (genvar g = 0; g < NUM_TARGETS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_q[g] <= '0;
      else if (we_i && sel_i == SEL_W'(g))       regs_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_TARGETS; i++) begin
      if (sel_i == SEL_W'(i)) rd_mux = regs_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= re_i ? rd_mux : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/vtimer_cmp_router.sv
module vtimer_cmp_router
  import vtcr_pkg::*;
#(
  parameter int unsigned       DATA_W    = 64,
  parameter int unsigned       CODE_W    = 8,
  parameter logic [CODE_W-1:0] TRAP_CODE = 8'h04,
  parameter logic [CODE_W-1:0] HYP_CODE  = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        level_i,
  input  logic              secure_i,
  input  logic              host_i,
  input  logic              aa32_i,
  input  logic              l1_64_i,
  input  logic              l2_en_i,
  input  logic              l2_64_i,
  input  logic              sec_l2_i,
  input  logic              cnt_virt_ext_i,
  input  logic              l0_timer_en64_i,
  input  logic              l0_timer_en32_i,
  input  logic              host_l0_timer_en_i,
  input  logic              trap_gen_i,
  input  logic              l1_timer_trap_i,
  output logic              rsp_valid_o,
  output logic [2:0]        rsp_kind_o,
  output logic [1:0]        rsp_level_o,
  output logic [CODE_W-1:0] rsp_code_o,
  output logic [SEL_W-1:0]  rsp_sel_o,
  output logic [DATA_W-1:0] rdata_o
);
  ctx_t              ctx;
  outcome_e          kind_d;
  logic [1:0]        lvl_d;
  logic [CODE_W-1:0] code_d;
  sel_e              sel_d;
  logic              is_access;

  assign ctx = '{
    level:        level_i,
    secure:       secure_i,
    host:         host_i,
    aa32:         aa32_i,
    l1_64:        l1_64_i,
    l2_en:        l2_en_i,
    l2_64:        l2_64_i,
    sec_l2:       sec_l2_i,
    cnt_virt_ext: cnt_virt_ext_i,
    l0_en64:      l0_timer_en64_i,
    l0_en32:      l0_timer_en32_i,
    host_l0_en:   host_l0_timer_en_i,
    trap_gen:     trap_gen_i,
    l1_trap:      l1_timer_trap_i
  };

  vtcr_decide #(
    .CODE_W   (CODE_W),
    .TRAP_CODE(TRAP_CODE),
    .HYP_CODE (HYP_CODE)
  ) u_decide (
    .ctx_i (ctx),
    .kind_o(kind_d),
    .lvl_o (lvl_d),
    .code_o(code_d),
    .sel_o (sel_d)
  );

  assign is_access = req_i && (kind_d == OUT_ACCESS);

  vtcr_bank #(.DATA_W(DATA_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (is_access && wr_i),
    .re_i   (is_access && !wr_i),
    .sel_i  (sel_d),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_kind_o  <= OUT_ACCESS;
      rsp_level_o <= '0;
      rsp_code_o  <= '0;
      rsp_sel_o   <= SEL_VIRT;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        rsp_kind_o  <= kind_d;
        rsp_level_o <= lvl_d;
        rsp_code_o  <= code_d;
        rsp_sel_o   <= sel_d;
      end
    end
  end
endmodule

// File: rtl/vtimer_cmp_router_chk.sv
module vtimer_cmp_router_chk
  import vtcr_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              aa32_i,
  input logic [1:0]        level_i,
  input logic              rsp_valid_o,
  input logic [2:0]        rsp_kind_o,
  input logic [1:0]        rsp_level_o,
  input logic [CODE_W-1:0] rsp_code_o,
  input logic [SEL_W-1:0]  rsp_sel_o,
  input logic [DATA_W-1:0] rdata_o
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o); // R8
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o); // R8
  AST_NO_AA32_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !aa32_i) |=> (rsp_kind_o == OUT_UNDEF)); // R1
  AST_HIGH_LEVEL_VIRT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && aa32_i && level_i[1]) |=> (rsp_kind_o == OUT_ACCESS && rsp_sel_o == SEL_VIRT)); // R7
  AST_NO_DATA_ON_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o != OUT_ACCESS) |-> (rdata_o == '0)); // R9
  AST_HV_SEL_ONLY_L0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_sel_o != SEL_VIRT) |-> (rsp_kind_o == OUT_ACCESS && $past(level_i) == 2'd0)); // R6
  AST_TRAP_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == OUT_TRAP) |-> (rsp_code_o == CODE_W'(8'h04) && rsp_level_o != 2'd0 && rsp_level_o != 2'd3)); // R2
endmodule

bind vtimer_cmp_router vtimer_cmp_router_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/vtimer_cmp_router_tb_top.sv
module vtimer_cmp_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [63:0] wdata = '0;
  logic [1:0]  level = '0;
  logic secure = 0, host = 0, aa32 = 1, l1_64 = 1, l2_en = 1, l2_64 = 1, sec_l2 = 1;
  logic cve = 0, en64 = 1, en32 = 1, host_en = 1, tgen = 0, l1_trap = 0;
  logic        rsp_valid;
  logic [2:0]  rsp_kind;
  logic [1:0]  rsp_level;
  logic [7:0]  rsp_code;
  logic [1:0]  rsp_sel;
  logic [63:0] rdata;

  int checks = 0;
  int errors = 0;
  logic [63:0] mdl [3];
  logic [63:0] last_rdata;
  logic [2:0]  last_kind;

  always #5 clk = ~clk;

  vtimer_cmp_router dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .wdata_i(wdata),
    .level_i(level), .secure_i(secure), .host_i(host), .aa32_i(aa32),
    .l1_64_i(l1_64), .l2_en_i(l2_en), .l2_64_i(l2_64), .sec_l2_i(sec_l2),
    .cnt_virt_ext_i(cve), .l0_timer_en64_i(en64), .l0_timer_en32_i(en32),
    .host_l0_timer_en_i(host_en), .trap_gen_i(tgen), .l1_timer_trap_i(l1_trap),
    .rsp_valid_o(rsp_valid), .rsp_kind_o(rsp_kind), .rsp_level_o(rsp_level),
    .rsp_code_o(rsp_code), .rsp_sel_o(rsp_sel), .rdata_o(rdata)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // expected response, derived from the requirement text
  task automatic expect_rsp(output logic [2:0] k, output logic [1:0] l,
                            output logic [7:0] c, output logic [1:0] s, output string tag);
    bit l2_64_on = l2_en && l2_64;
    bit tt = l2_64_on && cve && l1_trap;
    k = 3'd0; l = 2'd0; c = 8'h00; s = 2'd0; tag = "R7";
    if (!aa32) begin k = 3'd1; tag = "R1"; end
    else if (level == 2'd0) begin
      tag = "R6";
      if (l1_64 && !host && !en64) begin
        k = 3'd2; c = 8'h04; l = (l2_64_on && tgen) ? 2'd2 : 2'd1; tag = "R2";
      end else if (!l1_64 && !en32) begin
        tag = "R3";
        if (l2_64_on && tgen) begin k = 3'd2; c = 8'h04; l = 2'd2; end
        else if (l2_en && !l2_64 && tgen) begin k = 3'd3; c = 8'h00; l = 2'd2; end
        else k = 3'd1;
      end else if (host && l2_64 && !host_en) begin
        k = 3'd2; c = 8'h04; l = 2'd2; tag = "R4";
      end else if (!host && tt) begin
        k = 3'd2; c = 8'h04; l = 2'd2; tag = "R5";
      end else if (host && secure && sec_l2) s = 2'd2;
      else if (host && !secure) s = 2'd1;
    end else if (level == 2'd1 && tt) begin
      k = 3'd2; c = 8'h04; l = 2'd2; tag = "R5";
    end
  endtask

  task automatic xact();
    logic [2:0] k; logic [1:0] l; logic [7:0] c; logic [1:0] s; string tag;
    logic [63:0] exp_rd;
    @(negedge clk);
    req = 1'b1;
    expect_rsp(k, l, c, s, tag);
    exp_rd = (k == 3'd0 && !wr) ? mdl[s] : 64'h0;
    @(negedge clk);
    req = 1'b0;
    check(rsp_valid == 1'b1, "R8", "valid", 64'(rsp_valid), 64'd1);
    check(rsp_kind == k, tag, "kind", 64'(rsp_kind), 64'(k));
    if (k != 3'd0 && k != 3'd1) begin
      check(rsp_level == l, tag, "level", 64'(rsp_level), 64'(l));
      check(rsp_code == c, tag, "code", 64'(rsp_code), 64'(c));
    end
    if (k == 3'd0) check(rsp_sel == s, tag, "sel", 64'(rsp_sel), 64'(s));
    check(rdata == exp_rd, "R9", "rdata", rdata, exp_rd);
    last_rdata = rdata;
    last_kind = rsp_kind;
    if (k == 3'd0 && wr) mdl[s] = wdata;
  endtask

  task automatic clean_ctx();
    aa32 = 1; l1_64 = 1; l2_en = 1; l2_64 = 1; sec_l2 = 1; cve = 1; l1_trap = 0;
    en64 = 1; en32 = 1; host_en = 1; tgen = 0; secure = 0; host = 0;
  endtask

  // target 0: level 3; target 1: host non-secure; target 2: host secure
  task automatic aim(input int t);
    clean_ctx();
    level = (t == 0) ? 2'd3 : 2'd0;
    host = (t != 0);
    secure = (t == 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 3; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11", "valid after reset", 64'(rsp_valid), 64'd0);

    // reset contents of all three targets
    for (int t = 0; t < 3; t++) begin
      aim(t); wr = 0; xact();
      check(last_rdata == 64'h0, "R11", "register after reset", last_rdata, 64'h0);
    end

    // distinct writes then read-back: selection and isolation
    for (int t = 0; t < 3; t++) begin
      aim(t); wr = 1; wdata = 64'hA5A5_0000_0000_0000 | 64'(t + 1); xact();
    end
    for (int t = 0; t < 3; t++) begin
      aim(t); wr = 0; xact();
      check(last_rdata == (64'hA5A5_0000_0000_0000 | 64'(t + 1)), "R10", "write isolation",
            last_rdata, 64'hA5A5_0000_0000_0000 | 64'(t + 1));
    end

    // missing 32-bit support at level 3: write must be dropped
    aim(0); aa32 = 0; wr = 1; wdata = 64'hDEAD_BEEF_0000_0001; xact();
    check(last_kind == 3'd1, "R1", "undef at level 3", 64'(last_kind), 64'd1);
    aim(0); wr = 0; xact();
    check(last_rdata == 64'hA5A5_0000_0000_0001, "R10", "undef write dropped",
          last_rdata, 64'hA5A5_0000_0000_0001);

    // level-1 timer trap: write must be dropped
    aim(0); level = 2'd1; l1_trap = 1; wr = 1; wdata = 64'h1234; xact();
    check(last_kind == 3'd2, "R5", "level-1 trap", 64'(last_kind), 64'd2);
    aim(0); wr = 0; xact();
    check(last_rdata == 64'hA5A5_0000_0000_0001, "R10", "trap write dropped",
          last_rdata, 64'hA5A5_0000_0000_0001);

    // directed corners of the level-0 chain
    clean_ctx(); level = 0; en64 = 0; tgen = 1; wr = 0; xact();            // R2 to level 2
    clean_ctx(); level = 0; en64 = 0; l2_en = 0; tgen = 1; xact();         // R2 to level 1
    clean_ctx(); level = 0; l1_64 = 0; en32 = 0; l2_64 = 0; tgen = 1; xact(); // R3 hyp trap
    clean_ctx(); level = 0; l1_64 = 0; en32 = 0; xact();                   // R3 undef
    clean_ctx(); level = 0; host = 1; host_en = 0; xact();                 // R4
    clean_ctx(); level = 0; host = 1; secure = 1; sec_l2 = 0; xact();      // R6 falls to plain
    clean_ctx(); level = 0; host = 1; l1_trap = 1; xact();                 // R5 skipped in host mode

    // idle cycle: no response
    @(negedge clk);
    check(rsp_valid == 1'b0, "R8", "idle valid", 64'(rsp_valid), 64'd0);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      level = 2'($urandom_range(0, 3));
      aa32 = ($urandom_range(0, 7) != 0);
      secure = 1'($urandom); host = 1'($urandom); l1_64 = 1'($urandom);
      l2_en = 1'($urandom); l2_64 = 1'($urandom); sec_l2 = 1'($urandom);
      cve = 1'($urandom); en64 = ($urandom_range(0, 3) != 0);
      en32 = ($urandom_range(0, 3) != 0); host_en = ($urandom_range(0, 3) != 0);
      tgen = 1'($urandom); l1_trap = ($urandom_range(0, 3) == 0);
      wr = 1'($urandom); wdata = {$urandom, $urandom};
      xact();
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk);
        check(rsp_valid == 1'b0, "R8", "gap valid", 64'(rsp_valid), 64'd0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule